// File: doc/BRIEF.md
# Indirect Register Access Controller

This block is the host-side front end of a device whose internal register space is too large to map directly. The host sees a small window of 16-bit registers: a status register, a revision register, an address register and four data registers. A wide internal register is reached through an indirect transaction. The host loads the data registers and writes a target address to the address register, which starts the transaction. The host then polls the busy flag in status until the transaction ends. For a read, the selected 16-bit word of the target then appears in data register 0.

The address word encodes the target and the operation. Bits 15:12 give the functional-block type and bits 11:8 the instance. Bit 7 chooses read (1) or write (0). Bits 3:2 select a parameter, and bits 1:0 choose which 16-bit word is returned by a read. The internal registers are modelled as a register file of 64-bit entries. An entry is indexed by the low `TYPE_BITS` bits of the type field, then the low `INST_BITS` bits of the instance field, then the parameter field. The status register also holds two active-low reset controls, one for the whole device and one for the attached codec.

Top module: `iac_ctrl`

## Requirements
- R1: After `rst_n` deasserts, status (0x10), address (0x30) and all data registers (0x40, 0x50, 0x60, 0x70) read 0x0000, and both `glb_rst_n` and `codec_rst_n` are low.
- R2: Status bit 3 (device run, active-low reset) and bit 4 (codec run) are read/write. `glb_rst_n` follows bit 3, and `codec_rst_n` is high only when both bits are 1. Status bit 0 is the busy flag and cannot be written.
- R3: Reading 0x20 returns `AUDIO_ABSENT` in bit 15 (0 means audio present), `BOARD_REV` in bits 14:12, `MAJOR_REV` in bits 7:4 and `MINOR_REV` in bits 3:0, with all other bits 0.
- R4: A write to 0x30 while idle and with status bit 3 set latches the address and starts a transaction. Status bit 0 then reads 1 for exactly `BUSY_CYCLES` cycles and returns to 0.
- R5: A write to 0x30 while busy is ignored. The latched address keeps its value and busy ends on the original schedule.
- R6: A transaction with address bit 7 = 0 writes the 64-bit value {data3, data2, data1, data0} into the selected entry. The value written is the one held in the data registers at the moment of the address write, so later data-register writes during the transaction do not change it.
- R7: A transaction with address bit 7 = 1 loads data register 0, when busy falls, with word n (bits 16n+15:16n) of the selected entry, where n is address bits 1:0. Data registers 1 to 3 are left unchanged.
- R8: Entries whose parameter fields (address bits 3:2) differ are independent. A write to one entry leaves the others unchanged.
- R9: While status bit 3 is 0, any running transaction is aborted in the same cycle as the status write, the register file is cleared to zero, and writes to 0x30 are ignored.
- R10: Data registers at 0x40, 0x50, 0x60 and 0x70 are host read/write. Addresses outside the window read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe for one cycle |
| host_addr | input | 8 | Host byte address of the window register |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for `host_addr` (combinational) |
| glb_rst_n | output | 1 | Device reset, active low, from status bit 3 |
| codec_rst_n | output | 1 | Codec reset, active low, from status bits 3 and 4 |

## Verification
The bench builds the block with `BUSY_CYCLES` = 5 and non-default revision values, with `AUDIO_ABSENT` set. With these values, every busy cycle can be counted one by one. They also leave room for an address write and a data write to land inside a transaction, and for an abort to hit a transaction in flight. The distinct revision fields make a misplaced bit field visible. The default `TYPE_BITS` and `INST_BITS` give 64 entries, so the parameter field can tell apart entries that share a type and an instance.

// File: rtl/iac_pkg.sv
package iac_pkg;

    localparam int WORD_W    = 16;
    localparam int NUM_DATA  = 4;
    localparam int WIDE_W    = WORD_W * NUM_DATA;
    localparam int HADDR_W   = 8;

    localparam logic [HADDR_W-1:0] OFS_STAT  = 8'h10;
    localparam logic [HADDR_W-1:0] OFS_REV   = 8'h20;
    localparam logic [HADDR_W-1:0] OFS_ADDR  = 8'h30;
    localparam logic [HADDR_W-1:0] OFS_DATA0 = 8'h40;
    localparam int                 DATA_STEP = 16;

    localparam int BIT_BUSY   = 0;
    localparam int BIT_GRUN   = 3;
    localparam int BIT_CRUN   = 4;
    localparam int BIT_RDSEL  = 7;

    typedef struct packed {
        logic                             grun;
        logic                             crun;
        logic [WORD_W-1:0]                iaddr;
        logic [NUM_DATA-1:0][WORD_W-1:0]  data;
        logic [WIDE_W-1:0]                snap;
    } ctl_t;

    function automatic logic [HADDR_W-1:0] data_ofs(input int idx);
        return HADDR_W'(int'(OFS_DATA0) + DATA_STEP * idx);
    endfunction

endpackage

// File: rtl/iac_txn_seq.sv
module iac_txn_seq #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        done  = seq_q.busy && (seq_q.cnt == '0) && !abort;
        if (abort) begin
            seq_d.busy = 1'b0;
            seq_d.cnt  = '0;
        end else if (start && !seq_q.busy) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = CNT_W'(BUSY_CYCLES - 1);
        end else if (seq_q.busy) begin
            if (seq_q.cnt == '0) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy = seq_q.busy;

    // run-length checker: counts consecutive busy cycles
    logic [CNT_W:0] run_d, run_q;
    always_comb run_d = busy ? run_q + 1'b1 : '0;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    AST_BUSY_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(run_q) < BUSY_CYCLES)) else $error("busy too long"); // R4

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !abort) |=> busy) else $error("start lost"); // R4

endmodule

// File: rtl/iac_regfile.sv
module iac_regfile #(
    parameter int IDX_W  = 6,
    parameter int WORD_W = 16,
    parameter int NWORDS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       we,
    input  logic [IDX_W-1:0]           widx,
    input  logic [WORD_W*NWORDS-1:0]   wdata,
    input  logic [IDX_W-1:0]           ridx,
    input  logic [$clog2(NWORDS)-1:0]  rsel,
    output logic [WORD_W-1:0]          rword
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int WIDE_W  = WORD_W * NWORDS;

    logic [WIDE_W-1:0] rf_d [ENTRIES];
    logic [WIDE_W-1:0] rf_q [ENTRIES];

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (clr)                                  rf_d[e] = '0;
            else if (we && (widx == IDX_W'(e)))       rf_d[e] = wdata;
            else                                      rf_d[e] = rf_q[e];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) rf_q[e] <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) rf_q[e] <= rf_d[e];
        end
    end

    assign rword = rf_q[ridx][int'(rsel)*WORD_W +: WORD_W];

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rword == '0)) else $error("entry survived clear"); // R9

endmodule

// File: rtl/iac_ctrl.sv
module iac_ctrl
    import iac_pkg::*;
#(
    parameter int          BUSY_CYCLES  = 4,
    parameter int          TYPE_BITS    = 2,
    parameter int          INST_BITS    = 2,
    parameter logic [2:0]  BOARD_REV    = 3'd1,
    parameter logic [3:0]  MAJOR_REV    = 4'd1,
    parameter logic [3:0]  MINOR_REV    = 4'd0,
    parameter logic        AUDIO_ABSENT = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    output logic               glb_rst_n,
    output logic               codec_rst_n
);
    localparam int IDX_W = TYPE_BITS + INST_BITS + 2;
    localparam logic [WORD_W-1:0] REV_WORD =
        {AUDIO_ABSENT, BOARD_REV, 4'b0000, MAJOR_REV, MINOR_REV};

    ctl_t ctl_d, ctl_q;

    logic               busy, done, start, abort;
    logic               wr_stat, wr_addr;
    logic [NUM_DATA-1:0] wr_data;
    logic [IDX_W-1:0]   xidx;
    logic [WORD_W-1:0]  rword;

    assign wr_stat = host_we && (host_addr == OFS_STAT);
    assign wr_addr = host_we && (host_addr == OFS_ADDR);

    for (genvar g = 0; g < NUM_DATA; g++) begin : g_dsel
        assign wr_data[g] = host_we && (host_addr == data_ofs(g));
    end

    assign start = wr_addr && !busy && ctl_q.grun;
    assign xidx  = {ctl_q.iaddr[12 +: TYPE_BITS],
                    ctl_q.iaddr[8  +: INST_BITS],
                    ctl_q.iaddr[3:2]};

    always_comb begin
        ctl_d = ctl_q;
        if (wr_stat) begin
            ctl_d.grun = host_wdata[BIT_GRUN];
            ctl_d.crun = host_wdata[BIT_CRUN];
        end
        for (int i = 0; i < NUM_DATA; i++) begin
            if (wr_data[i]) ctl_d.data[i] = host_wdata;
        end
        if (start) begin
            ctl_d.iaddr = host_wdata;
            ctl_d.snap  = ctl_q.data;
        end
        if (done && ctl_q.iaddr[BIT_RDSEL]) begin
            ctl_d.data[0] = rword;
        end
    end

    assign abort = !ctl_d.grun;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    iac_txn_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .abort (abort),
        .busy  (busy),
        .done  (done)
    );

    iac_regfile #(.IDX_W(IDX_W), .WORD_W(WORD_W), .NWORDS(NUM_DATA)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (abort),
        .we    (done && !ctl_q.iaddr[BIT_RDSEL]),
        .widx  (xidx),
        .wdata (ctl_q.snap),
        .ridx  (xidx),
        .rsel  (ctl_q.iaddr[1:0]),
        .rword (rword)
    );

    always_comb begin
        host_rdata = '0;
        if (host_addr == OFS_STAT) begin
            host_rdata[BIT_BUSY] = busy;
            host_rdata[BIT_GRUN] = ctl_q.grun;
            host_rdata[BIT_CRUN] = ctl_q.crun;
        end else if (host_addr == OFS_REV) begin
            host_rdata = REV_WORD;
        end else if (host_addr == OFS_ADDR) begin
            host_rdata = ctl_q.iaddr;
        end else begin
            for (int i = 0; i < NUM_DATA; i++) begin
                if (host_addr == data_ofs(i)) host_rdata = ctl_q.data[i];
            end
        end
    end

    assign glb_rst_n   = ctl_q.grun;
    assign codec_rst_n = ctl_q.grun & ctl_q.crun;

    AST_ADDR_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctl_q.iaddr)) else $error("address changed in flight"); // R5

    AST_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_rst_n |-> !busy) else $error("busy under device reset"); // R9

    AST_READ_SPARES_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ctl_q.iaddr[BIT_RDSEL] && !host_we) |=> $stable(ctl_q.data[NUM_DATA-1:1]))
        else $error("read touched upper data"); // R7

endmodule

// File: tb/sim_iac_ctrl.sv
module sim_iac_ctrl;
    localparam int BC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [15:0] host_wdata = 16'h0000;
    logic [15:0] host_rdata;
    logic        glb_rst_n, codec_rst_n;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    iac_ctrl #(
        .BUSY_CYCLES(BC), .BOARD_REV(3'd5), .MAJOR_REV(4'hA),
        .MINOR_REV(4'h3), .AUDIO_ABSENT(1'b1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .glb_rst_n(glb_rst_n), .codec_rst_n(codec_rst_n)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares queued expectations away from the clock edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            chk(it.tag, host_rdata, it.exp);
        end
    end

    // all tasks start and end just after a rising edge
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
        item_t it;
        host_addr = a;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic wait_idle();
        host_addr = 8'h10;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (host_rdata[0] == 1'b0) break;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        rd(8'h10, 16'h0000, "R1 status");
        rd(8'h30, 16'h0000, "R1 address");
        rd(8'h40, 16'h0000, "R1 data0");
        rd(8'h70, 16'h0000, "R1 data3");
        chk("R1 glb_rst_n", {15'd0, glb_rst_n}, 16'h0000);
        chk("R1 codec_rst_n", {15'd0, codec_rst_n}, 16'h0000);

        // R3 revision
        rd(8'h20, 16'hD0A3, "R3 revision");

        // R9 address write ignored while held in reset
        wr(8'h30, 16'h1204);
        rd(8'h10, 16'h0000, "R9 no busy in reset");
        rd(8'h30, 16'h0000, "R9 address not latched");

        // R2 status bits
        wr(8'h10, 16'h0010);
        rd(8'h10, 16'h0010, "R2 codec bit only");
        chk("R2 codec gated by global", {15'd0, codec_rst_n}, 16'h0000);
        wr(8'h10, 16'h0008);
        chk("R2 glb follows bit3", {15'd0, glb_rst_n}, 16'h0001);
        chk("R2 codec held", {15'd0, codec_rst_n}, 16'h0000);
        wr(8'h10, 16'h0019);
        rd(8'h10, 16'h0018, "R2 busy bit not writable");
        chk("R2 codec released", {15'd0, codec_rst_n}, 16'h0001);

        // R10 data registers and unmapped space
        wr(8'h40, 16'h1357);
        wr(8'h50, 16'h2468);
        wr(8'h60, 16'h9ACE);
        wr(8'h70, 16'hBDF0);
        rd(8'h40, 16'h1357, "R10 data0");
        rd(8'h60, 16'h9ACE, "R10 data2");
        rd(8'h38, 16'h0000, "R10 unmapped");
        rd(8'h80, 16'h0000, "R10 outside window");

        // R4 busy timing, R6 indirect write
        wr(8'h30, 16'h1204);
        for (int k = 0; k < BC; k++) rd(8'h10, 16'h0019, "R4 busy high");
        rd(8'h10, 16'h0018, "R4 busy cleared");
        rd(8'h30, 16'h1204, "R4 address latched");

        // R7 indirect reads with word select
        wr(8'h30, 16'h1284);
        wait_idle();
        rd(8'h40, 16'h1357, "R7 word0");
        wr(8'h30, 16'h1287);
        wait_idle();
        rd(8'h40, 16'hBDF0, "R7 word3");
        rd(8'h50, 16'h2468, "R7 data1 untouched");
        rd(8'h70, 16'hBDF0, "R7 data3 untouched");

        // R8 independent entries
        wr(8'h40, 16'h0F0F);
        wr(8'h30, 16'h1208);
        wait_idle();
        wr(8'h30, 16'h1288);
        wait_idle();
        rd(8'h40, 16'h0F0F, "R8 new entry");
        wr(8'h30, 16'h1284);
        wait_idle();
        rd(8'h40, 16'h1357, "R8 old entry kept");

        // R6 snapshot at start
        wr(8'h40, 16'h4444);
        wr(8'h30, 16'h120C);
        wr(8'h40, 16'hEEEE);
        wait_idle();
        wr(8'h30, 16'h128C);
        wait_idle();
        rd(8'h40, 16'h4444, "R6 data snapshot");

        // R5 address write while busy ignored
        wr(8'h30, 16'h1285);
        wr(8'h30, 16'h3000);
        for (int k = 0; k < BC - 1; k++) rd(8'h10, 16'h0019, "R5 busy on schedule");
        rd(8'h10, 16'h0018, "R5 busy ends");
        rd(8'h30, 16'h1285, "R5 address kept");
        rd(8'h40, 16'h2468, "R5 original read done");

        // R9 abort, clear, and block
        wr(8'h30, 16'h1284);
        wr(8'h10, 16'h0000);
        rd(8'h10, 16'h0000, "R9 aborted");
        chk("R9 glb asserted", {15'd0, glb_rst_n}, 16'h0000);
        wr(8'h30, 16'h1208);
        rd(8'h10, 16'h0000, "R9 still idle");
        rd(8'h30, 16'h1284, "R9 address blocked");
        wr(8'h10, 16'h0018);
        wr(8'h30, 16'h1288);
        wait_idle();
        rd(8'h40, 16'h0000, "R9 entry cleared");

        @(posedge clk); #1;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule